// File: doc/BRIEF.md
# Key Event FIFO with Peek Read

This block queues press and release events that a key scanner delivers and hands them to a host through two kinds of read. There are 16 entries, kept as a circular buffer with a head pointer and a length. Each event is stored as one byte. The low seven bits hold the key code and the top bit holds the key state.

The host has two ways to read:
- A consuming read first advances the head and then returns the byte at the new head. It only does so while two or more entries are stored; otherwise it returns zero and changes nothing.
- A peek read returns the entry at a given offset from the head and removes nothing.

Other behaviour:
- Every accepted event pulses a keypad interrupt request.
- A push into a full buffer is dropped and sets a sticky overflow error.
- While the host-side error status is raised and the overflow error is set, events are ignored without any further effect.
- A configuration write empties the buffer.

All inputs are sampled on the rising clock edge. All state and read results change just after that edge. Reset is synchronous and active high.

Top module: `key_event_fifo`

## Requirements
- R1: After reset, `pop_data`, `peek_data`, `kp_set` and `ovf_err` are all zero and the buffer is empty.
- R2: A stored event byte carries `ev_code` in bits 6:0 and `ev_pressed` in bit 7. A 1 in bit 7 means pressed.
- R3: A cycle with `peek_en` high and `peek_idx` = k loads `peek_data` for the following cycles until the next peek. It loads the entry at (head + k) mod 16 if k is less than the length, and 0 otherwise. A peek changes neither the head nor the length.
- R4: A cycle with `rd_pop` high loads `pop_data` for the following cycles until the next pop.
  - If the length is 1 or less, it loads 0 and leaves the head and length unchanged.
  - Otherwise the head advances by one, the length drops by one, and it loads the entry at the new head.
- R5: An accepted event is written at (head + length) mod 16. The head wraps modulo 16.
- R6: An event arriving while 16 entries are stored is dropped, and `ovf_err` goes high. `ovf_err` stays high until reset.
- R7: While `err_status` and `ovf_err` are both high, `ev_valid` is ignored: nothing is stored and `kp_set` stays low.
- R8: `kp_set` is high for exactly the one cycle after each accepted event.
- R9: A cycle with `cfg_clear` high sets the head and length to zero. A push in the same cycle is dropped. A pop in the same cycle loads 0 and removes nothing.
- R10: When an event is accepted in the same cycle as a successful pop, both take effect and the length stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Key event present this cycle |
| ev_code | input | 7 | Key code of the event |
| ev_pressed | input | 1 | 1 for press, 0 for release |
| err_status | input | 1 | Host-side error status flag |
| cfg_clear | input | 1 | Configuration write: empty the buffer |
| rd_pop | input | 1 | Consuming read request |
| pop_data | output | 8 | Result of the last consuming read |
| peek_en | input | 1 | Peek read request |
| peek_idx | input | 4 | Offset from the head for a peek |
| peek_data | output | 8 | Result of the last peek |
| kp_set | output | 1 | Keypad interrupt request pulse |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The assertions assume the inputs are settled at every rising edge. They also assume `err_status` is a level that the surrounding logic drives, with no timing tie to `ev_valid`.

The assertion on simultaneous push and pop covers only cycles where the length is between 2 and 15. The full-buffer case is judged on the length at the start of the cycle, so a push there is dropped even with a pop in the same cycle. The stimulus drives every input on the falling edge and returns it to zero one cycle later. It reaches both full and wrapped buffer states through ordinary pushes and pops, with no reset in between.

// File: rtl/kef_pkg.sv
package kef_pkg;
  localparam int KEF_CODE_W = 7;   // key code width, state bit sits above it
  localparam int KEF_DEPTH  = 16;  // entries, must be a power of two
endpackage

// File: rtl/kef_store.sv
// Event storage: one write port and two registered, enabled read ports.
module kef_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_q,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ra_en) ra_q <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    if (rb_en) rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/kef_ctrl.sv
// Head, length, overflow and interrupt control for the key event FIFO.
module kef_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic          err_status,
  input  logic          cfg_clear,
  input  logic          rd_pop,
  input  logic          peek_en,
  input  logic [AW-1:0] peek_idx,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] pop_addr,
  output logic [AW-1:0] peek_addr,
  output logic          pop_ok_q,
  output logic          peek_ok_q,
  output logic          kp_set_q,
  output logic          ovf_err_q
);
  logic [AW-1:0] head_q;
  logic [LW-1:0] len_q;
  logic          full, push_req, push_ok, ovf_hit, pop_ok, peek_hit;

  always_comb begin
    full      = (len_q == LW'(DEPTH));
    push_req  = ev_valid && !(err_status && ovf_err_q);
    push_ok   = push_req && !full && !cfg_clear;
    ovf_hit   = push_req && full && !cfg_clear;
    pop_ok    = rd_pop && (len_q > LW'(1)) && !cfg_clear;
    peek_hit  = LW'(peek_idx) < len_q;
    we        = push_ok;
    waddr     = head_q + len_q[AW-1:0];
    pop_addr  = head_q + AW'(1);
    peek_addr = head_q + peek_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      len_q     <= '0;
      ovf_err_q <= 1'b0;
      kp_set_q  <= 1'b0;
      pop_ok_q  <= 1'b0;
      peek_ok_q <= 1'b0;
    end else begin
      kp_set_q <= push_ok;
      if (ovf_hit) ovf_err_q <= 1'b1;
      if (cfg_clear) begin
        head_q <= '0;
        len_q  <= '0;
      end else begin
        head_q <= head_q + AW'(pop_ok);
        len_q  <= len_q + LW'(push_ok) - LW'(pop_ok);
      end
      if (rd_pop)  pop_ok_q  <= pop_ok;
      if (peek_en) peek_ok_q <= peek_hit;
    end
  end

  // R6: length never exceeds the depth
  a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
    len_q <= LW'(DEPTH));

  // R6: overflow error is sticky
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err_q |=> ovf_err_q);

  // R9: configuration write empties the buffer
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |=> (len_q == '0) && (head_q == '0));

  // R4: short pop leaves the head where it was
  a_r4_short_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && (len_q <= LW'(1)) && !cfg_clear) |=> $stable(head_q));

  // R10: push and pop together keep the length
  a_r10_push_pop_len: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !err_status && rd_pop && !cfg_clear &&
     (len_q > LW'(1)) && (len_q < LW'(DEPTH))) |=> $stable(len_q));

  // R7: ignored events touch neither length nor interrupt
  a_r7_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && err_status && ovf_err_q && !rd_pop && !cfg_clear)
      |=> ($stable(len_q) && !kp_set_q));

  // R8: interrupt pulse only follows an event
  a_r8_kp_after_event: assert property (@(posedge clk) disable iff (rst)
    kp_set_q |-> $past(ev_valid));
endmodule

// File: rtl/key_event_fifo.sv
// Key event FIFO with consuming and peek reads.
module key_event_fifo
  import kef_pkg::*;
#(
  parameter int DEPTH  = KEF_DEPTH,
  parameter int CODE_W = KEF_CODE_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = CODE_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic          ev_pressed,
  input  logic          err_status,
  input  logic          cfg_clear,
  input  logic          rd_pop,
  output logic [W-1:0]  pop_data,
  input  logic          peek_en,
  input  logic [AW-1:0] peek_idx,
  output logic [W-1:0]  peek_data,
  output logic          kp_set,
  output logic          ovf_err
);
  logic          we, pop_ok_q, peek_ok_q;
  logic [AW-1:0] waddr, pop_addr, peek_addr;
  logic [W-1:0]  pop_raw, peek_raw;

  kef_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .err_status(err_status),
    .cfg_clear(cfg_clear), .rd_pop(rd_pop), .peek_en(peek_en),
    .peek_idx(peek_idx), .we(we), .waddr(waddr), .pop_addr(pop_addr),
    .peek_addr(peek_addr), .pop_ok_q(pop_ok_q), .peek_ok_q(peek_ok_q),
    .kp_set_q(kp_set), .ovf_err_q(ovf_err)
  );

  kef_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata({ev_pressed, ev_code}),
    .ra_en(rd_pop), .ra_addr(pop_addr), .ra_q(pop_raw),
    .rb_en(peek_en), .rb_addr(peek_addr), .rb_q(peek_raw)
  );

  assign pop_data  = pop_ok_q  ? pop_raw  : '0;
  assign peek_data = peek_ok_q ? peek_raw : '0;

  // R1: outputs read zero right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pop_data == '0) && (peek_data == '0) && !kp_set && !ovf_err);
endmodule

// File: tb/tb_key_event_fifo.sv
`timescale 1ns/1ps
module tb_key_event_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 0, ev_pressed = 0, err_status = 0, cfg_clear = 0;
  logic rd_pop = 0, peek_en = 0;
  logic [6:0] ev_code = '0;
  logic [3:0] peek_idx = '0;
  logic [7:0] pop_data, peek_data;
  logic kp_set, ovf_err;

  always #4 clk = ~clk;

  key_event_fifo dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_pressed(ev_pressed), .err_status(err_status), .cfg_clear(cfg_clear),
    .rd_pop(rd_pop), .pop_data(pop_data), .peek_en(peek_en),
    .peek_idx(peek_idx), .peek_data(peek_data), .kp_set(kp_set),
    .ovf_err(ovf_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mq [$];
  logic [7:0] exp_pop = 0, exp_peek = 0;
  logic exp_kp = 0, exp_ovf = 0;

  localparam logic [7:0] VEC [6] = '{8'h85, 8'h05, 8'hBC, 8'h3C, 8'h7F, 8'h80};

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one cycle from a falling edge to the next, model updated, outputs checked
  task automatic cyc(string tag, logic ev, logic [7:0] b, logic pop,
                     logic pk, logic [3:0] k, logic clr);
    bit full_old, ign, acc;
    ev_valid = ev; ev_code = b[6:0]; ev_pressed = b[7];
    rd_pop = pop; peek_en = pk; peek_idx = k; cfg_clear = clr;
    full_old = (mq.size() == 16);
    ign = err_status && exp_ovf;
    if (pk) exp_peek = (k < mq.size()) ? mq[k] : 8'h00;
    acc = ev && !ign && !clr && !full_old;
    if (ev && !ign && !clr && full_old) exp_ovf = 1;
    exp_kp = acc;
    if (clr) begin
      if (pop) exp_pop = 0;
      mq.delete();
    end else begin
      if (pop) begin
        if (mq.size() > 1) begin
          void'(mq.pop_front());
          exp_pop = mq[0];
        end else exp_pop = 0;
      end
      if (acc) mq.push_back(b);
    end
    @(negedge clk);
    ev_valid = 0; rd_pop = 0; peek_en = 0; cfg_clear = 0;
    chk({tag, " pop_data"}, pop_data, exp_pop);
    chk({tag, " peek_data"}, peek_data, exp_peek);
    chk({tag, " kp_set"}, {7'b0, kp_set}, {7'b0, exp_kp});
    chk({tag, " ovf_err"}, {7'b0, ovf_err}, {7'b0, exp_ovf});
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pop_data", pop_data, 8'h00);
    chk("R1 peek_data", peek_data, 8'h00);
    chk("R1 kp_set", {7'b0, kp_set}, 8'h00);
    chk("R1 ovf_err", {7'b0, ovf_err}, 8'h00);
    cyc("R1 empty peek", 0, 0, 0, 1, 0, 0);
    cyc("R1 empty pop", 0, 0, 1, 0, 0, 0);

    // table walk: R8 pulse per push, R2 byte format via peek
    foreach (VEC[i]) cyc("R8 push", 1, VEC[i], 0, 0, 0, 0);
    cyc("R8 pulse ends", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc("R2 peek", 0, 0, 0, 1, 4'(i), 0);
    chk("R2 pressed byte", peek_data, 8'h80);
    cyc("R3 peek past length", 0, 0, 0, 1, 4'd6, 0);
    cyc("R3 peek again no change", 0, 0, 0, 1, 4'd0, 0);
    chk("R3 peek head", peek_data, 8'h85);

    // R4 consuming reads down to one entry
    for (int i = 0; i < 5; i++) cyc("R4 pop", 0, 0, 1, 0, 0, 0);
    chk("R4 last pop value", pop_data, 8'h80);
    cyc("R4 pop with one left", 0, 0, 1, 0, 0, 0);
    cyc("R4 head kept", 0, 0, 0, 1, 4'd0, 0);

    // R5 wrap: fill to 16 with write positions crossing index 15
    for (int i = 0; i < 15; i++) cyc("R5 fill", 1, 8'(8'h10 + i + (i[0] << 7)), 0, 0, 0, 0);
    cyc("R5 peek last", 0, 0, 0, 1, 4'd15, 0);
    cyc("R5 peek mid", 0, 0, 0, 1, 4'd10, 0);

    // R6 overflow
    cyc("R6 push when full", 1, 8'h55, 0, 0, 0, 0);
    cyc("R6 contents kept", 0, 0, 0, 1, 4'd15, 0);
    cyc("R6 sticky", 0, 0, 0, 0, 0, 0);

    // R7 ignore while both flags high
    cyc("R7 make room", 0, 0, 1, 0, 0, 0);
    err_status = 1;
    cyc("R7 ignored push", 1, 8'h66, 0, 0, 0, 0);
    cyc("R7 not stored", 0, 0, 0, 1, 4'd15, 0);
    err_status = 0;
    cyc("R7 accepted push", 1, 8'h66, 0, 0, 0, 0);
    cyc("R7 stored", 0, 0, 0, 1, 4'd15, 0);

    // R10 push with pop in the same cycle
    cyc("R10 pop", 0, 0, 1, 0, 0, 0);
    cyc("R10 push+pop", 1, 8'hC1, 1, 0, 0, 0);
    cyc("R10 new tail", 0, 0, 0, 1, 4'd14, 0);
    cyc("R10 length kept", 0, 0, 0, 1, 4'd15, 0);

    // R9 clear beats push and pop
    cyc("R9 clear with push and pop", 1, 8'h77, 1, 0, 0, 1);
    cyc("R9 empty peek", 0, 0, 0, 1, 4'd0, 0);
    cyc("R9 empty pop", 0, 0, 1, 0, 0, 0);
    cyc("R9 refill a", 1, 8'h12, 0, 0, 0, 0);
    cyc("R9 refill b", 1, 8'h93, 0, 0, 0, 0);
    cyc("R9 pop after clear", 0, 0, 1, 0, 0, 0);
    chk("R9 head restarted", pop_data, 8'h93);

    report();
  end
endmodule